// File: doc/BRIEF.md
# PCIe MSI Capture and Interrupt Aggregator

This block sits in a PCIe root port and turns inbound message-signalled interrupts and legacy INTx messages into one interrupt line for the host. Message vectors are grouped into sets of 32. Every set has its own 64-bit capture address, a pending-status word and a per-vector enable word. An inbound memory write whose address equals a set's capture address marks one vector pending in that set, selected by the low bits of the write data. A vector's global number is its set index times 32 plus its bit position.

Above the sets sits a top-level status word with one summary bit per set and one bit per INTx line, and a top-level enable word with the same layout. The single interrupt output is raised whenever a top-level status bit and its enable are both set. INTx lines behave as levels: an assert message raises a line's status bit, and only the matching deassert message lowers it. Software reaches everything through a plain 32-bit register bus with single-cycle writes and combinational reads.

Top module: `msi_intx_aggr`

## Requirements
- R1: After reset every register reads 0 and irq_out is 0.
- R2: Set i has its capture address low word at offset 0xC00+i*0x10 and its high word at 0xC80+i*4, both read back as written; an inbound write whose 64-bit address equals {high,low} of set i, while bit i of the set-enable register at 0x190 is 1 and the data is below 32, sets bit data[4:0] of that set's status word at 0xC04+i*0x10 at the next clock edge.
- R3: Writing 1 to a bit of a set status word clears it and writing 0 leaves it; when a capture and a clear hit the same bit in the same cycle the bit ends up set.
- R4: An inbound write to a set whose set-enable bit is 0, with data of 32 or more, or with a non-matching address, changes no state.
- R5: Top status bit 8+i (offset 0x184) becomes 1 one edge after set i has a pending vector that is also enabled while the set is enabled, stays 1 after the pending vector is cleared, and writing 1 to it clears it only when nothing in the set is still pending and enabled.
- R6: The per-vector enable word at 0xC08+i*0x10 gates only the summary: a disabled vector is still recorded in status but does not raise the summary bit.
- R7: An INTx assert pulse on line n sets top status bit 24+n at the next edge; the bit stays 1, also through a write of 1 to it, until a deassert pulse on line n clears it.
- R8: The top enable register at 0x180 keeps bits 15:8 (set summaries) and 27:24 (INTx) and reads 0 elsewhere; irq_out is 1 exactly when some top status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msi_valid | input | 1 | Inbound memory write present |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data (vector number) |
| intx_assert | input | 4 | Per-line INTx assert message pulse |
| intx_deassert | input | 4 | Per-line INTx deassert message pulse |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
A capture or a status clear shows in the set status word one edge after the write, while the summary bit, and with it irq_out, follows one edge later because it is registered from the status word; INTx status and its effect on irq_out appear one edge after the message pulse. Register reads are combinational, so the bench drives every input just after a rising edge and samples outputs at the falling edge of the same cycle, with the reference model stepped on the rising edge. The model is compared against reg_rdata and irq_out on every clock, and directed reads with fixed expected values cover the boundary sets, dropped writes, the capture-versus-clear collision and the summary re-arm.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int REG_AW   = 12;
  localparam int IN_AW    = 64;
  localparam int MSI_LSB  = 8;
  localparam int INTX_LSB = 24;
  localparam logic [REG_AW-1:0] TOP_EN_OFS  = 12'h180;
  localparam logic [REG_AW-1:0] TOP_STS_OFS = 12'h184;
  localparam logic [REG_AW-1:0] SET_EN_OFS  = 12'h190;
  localparam logic [REG_AW-1:0] SET_BASE    = 12'hC00;
  localparam logic [REG_AW-1:0] SET_STRIDE  = 12'h010;
  localparam logic [REG_AW-1:0] HI_BASE     = 12'hC80;
  localparam logic [REG_AW-1:0] HI_STRIDE   = 12'h004;
endpackage

// File: rtl/msi_set_bank.sv
module msi_set_bank
  import msi_agg_pkg::*;
#(
  parameter int SET_IDX     = 0,
  parameter int VEC_PER_SET = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              in_valid,
  input  logic [IN_AW-1:0]  in_addr,
  input  logic [31:0]       in_data,
  output logic              pending,
  output logic [31:0]       rd_data
);
  localparam int VW = $clog2(VEC_PER_SET);
  localparam logic [REG_AW-1:0] A_LO  = SET_BASE + REG_AW'(SET_IDX) * SET_STRIDE;
  localparam logic [REG_AW-1:0] A_STS = A_LO + 12'h004;
  localparam logic [REG_AW-1:0] A_VEN = A_LO + 12'h008;
  localparam logic [REG_AW-1:0] A_HI  = HI_BASE + REG_AW'(SET_IDX) * HI_STRIDE;

  logic [31:0]            lo_q, hi_q;
  logic [VEC_PER_SET-1:0] sts_q, sts_d, ven_q;
  logic [VEC_PER_SET-1:0] cap_mask, w1c_mask;
  logic                   cap_hit, lo_we, hi_we, ven_we, sts_we;

  always_comb begin
    cap_hit  = in_valid && set_en && ({hi_q, lo_q} == in_addr) &&
               (in_data < 32'(VEC_PER_SET));
    cap_mask = cap_hit ? ({{(VEC_PER_SET-1){1'b0}}, 1'b1} << in_data[VW-1:0]) : '0;
    w1c_mask = (wr_en && addr == A_STS) ? wdata[VEC_PER_SET-1:0] : '0;
    lo_we    = wr_en && addr == A_LO;
    hi_we    = wr_en && addr == A_HI;
    ven_we   = wr_en && addr == A_VEN;
    sts_we   = cap_hit || (w1c_mask != '0);
    sts_d    = (sts_q & ~w1c_mask) | cap_mask;   // capture wins over clear
    pending  = set_en && ((sts_q & ven_q) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ven_q <= '0;
      sts_q <= '0;
    end else begin
      if (lo_we)  lo_q  <= wdata;
      if (hi_we)  hi_q  <= wdata;
      if (ven_we) ven_q <= wdata[VEC_PER_SET-1:0];
      if (sts_we) sts_q <= sts_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_LO)  rd_data = lo_q;
    if (addr == A_HI)  rd_data = hi_q;
    if (addr == A_STS) rd_data = 32'(sts_q);
    if (addr == A_VEN) rd_data = 32'(ven_q);
  end

  // R2: a capture leaves its vector pending
  a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> ((sts_q & $past(cap_mask)) == $past(cap_mask)));
  // R3: cleared bits that were not captured in the same cycle read 0
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((w1c_mask & ~cap_mask) != '0) |=> ((sts_q & $past(w1c_mask & ~cap_mask)) == '0));
  // R4: dropped inbound writes leave status untouched
  a_r4_drop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!set_en || in_data >= 32'(VEC_PER_SET)) && w1c_mask == '0)
      |=> $stable(sts_q));
endmodule

// File: rtl/intx_level.sv
module intx_level #(
  parameter int NUM_INTX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] assert_i,
  input  logic [NUM_INTX-1:0] deassert_i,
  output logic [NUM_INTX-1:0] level_o
);
  logic [NUM_INTX-1:0] lvl_q, lvl_d;
  logic                lvl_we;

  always_comb begin
    lvl_we = (assert_i | deassert_i) != '0;
    lvl_d  = assert_i | (lvl_q & ~deassert_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_we) lvl_q <= lvl_d;
  end

  assign level_o = lvl_q;

  // R7: an assert message raises the line
  a_r7_assert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (assert_i != '0) |=> ((lvl_q & $past(assert_i)) == $past(assert_i)));
  // R7: only a deassert message lowers a raised line
  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_q & ~deassert_i) != '0) |=>
      ((lvl_q & $past(lvl_q & ~deassert_i)) == $past(lvl_q & ~deassert_i)));
endmodule

// File: rtl/msi_intx_aggr.sv
module msi_intx_aggr
  import msi_agg_pkg::*;
#(
  parameter int NUM_SETS    = 8,
  parameter int VEC_PER_SET = 32,
  parameter int NUM_INTX    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                msi_valid,
  input  logic [IN_AW-1:0]    msi_addr,
  input  logic [31:0]         msi_data,
  input  logic [NUM_INTX-1:0] intx_assert,
  input  logic [NUM_INTX-1:0] intx_deassert,
  output logic                irq_out
);
  logic [NUM_SETS-1:0] ten_msi_q, set_en_q, sum_q, sum_d, sum_w1c, pend;
  logic [NUM_INTX-1:0] ten_intx_q, intx_lvl;
  logic [31:0]         bank_rd [NUM_SETS];
  logic                ten_we, sen_we, sum_we;

  generate
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
      msi_set_bank #(.SET_IDX(g), .VEC_PER_SET(VEC_PER_SET)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en_q[g]),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .in_valid (msi_valid),
        .in_addr  (msi_addr),
        .in_data  (msi_data),
        .pending  (pend[g]),
        .rd_data  (bank_rd[g])
      );
    end
  endgenerate

  intx_level #(.NUM_INTX(NUM_INTX)) u_intx (
    .clk        (clk),
    .rst_n      (rst_n),
    .assert_i   (intx_assert),
    .deassert_i (intx_deassert),
    .level_o    (intx_lvl)
  );

  always_comb begin
    ten_we  = reg_wr_en && reg_addr == TOP_EN_OFS;
    sen_we  = reg_wr_en && reg_addr == SET_EN_OFS;
    sum_w1c = (reg_wr_en && reg_addr == TOP_STS_OFS) ? reg_wdata[MSI_LSB +: NUM_SETS] : '0;
    sum_d   = pend | (sum_q & ~sum_w1c);   // re-arms while still pending
    sum_we  = (pend != '0) || (sum_w1c != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_msi_q  <= '0;
      ten_intx_q <= '0;
      set_en_q   <= '0;
      sum_q      <= '0;
    end else begin
      if (ten_we) begin
        ten_msi_q  <= reg_wdata[MSI_LSB +: NUM_SETS];
        ten_intx_q <= reg_wdata[INTX_LSB +: NUM_INTX];
      end
      if (sen_we) set_en_q <= reg_wdata[NUM_SETS-1:0];
      if (sum_we) sum_q    <= sum_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SETS; i++) reg_rdata = reg_rdata | bank_rd[i];
    if (reg_addr == TOP_EN_OFS) begin
      reg_rdata[MSI_LSB +: NUM_SETS]  = ten_msi_q;
      reg_rdata[INTX_LSB +: NUM_INTX] = ten_intx_q;
    end
    if (reg_addr == TOP_STS_OFS) begin
      reg_rdata[MSI_LSB +: NUM_SETS]  = sum_q;
      reg_rdata[INTX_LSB +: NUM_INTX] = intx_lvl;
    end
    if (reg_addr == SET_EN_OFS) reg_rdata[NUM_SETS-1:0] = set_en_q;
  end

  assign irq_out = ((sum_q & ten_msi_q) != '0) || ((intx_lvl & ten_intx_q) != '0);

  // R5: a pending, enabled vector raises its summary bit one edge later
  a_r5_summary_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> ((sum_q & $past(pend)) == $past(pend)));
  // R5: summary bits stay until cleared
  a_r5_summary_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_w1c == '0) |=> ((sum_q & $past(sum_q)) == $past(sum_q)));
  // R8: no enable, no interrupt
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ten_msi_q == '0 && ten_intx_q == '0) |-> !irq_out);
endmodule

// File: tb/tb_msi_intx_aggr.sv
module tb_msi_intx_aggr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic [3:0]  intx_assert = '0, intx_deassert = '0;
  logic        irq_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msi_intx_aggr dut (.*);

  // behavioural reference model
  logic [31:0] m_lo [8], m_hi [8], m_sts [8], m_ven [8];
  logic [7:0]  m_ten, m_sen, m_sum;
  logic [3:0]  m_tix, m_lvl;

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (a == 12'hC00 + 12'(16*i)) r = m_lo[i];
      if (a == 12'hC04 + 12'(16*i)) r = m_sts[i];
      if (a == 12'hC08 + 12'(16*i)) r = m_ven[i];
      if (a == 12'hC80 + 12'(4*i))  r = m_hi[i];
    end
    if (a == 12'h180) r = {4'h0, m_tix, 8'h00, m_ten, 8'h00};
    if (a == 12'h184) r = {4'h0, m_lvl, 8'h00, m_sum, 8'h00};
    if (a == 12'h190) r = {24'h0, m_sen};
    return r;
  endfunction

  function automatic logic m_irq();
    return ((m_sum & m_ten) != 0) || ((m_lvl & m_tix) != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_sts[i] = 0; m_ven[i] = 0;
      end
      m_ten = 0; m_sen = 0; m_sum = 0; m_tix = 0; m_lvl = 0;
    end else begin
      logic [7:0]  pend;
      logic [31:0] cap [8];
      for (int i = 0; i < 8; i++) begin
        pend[i] = m_sen[i] && ((m_sts[i] & m_ven[i]) != 0);
        cap[i]  = 0;
        if (msi_valid && m_sen[i] && {m_hi[i], m_lo[i]} == msi_addr && msi_data < 32)
          cap[i] = 32'd1 << msi_data;
      end
      if (reg_wr_en && reg_addr == 12'h184) m_sum = m_sum & ~reg_wdata[15:8];
      m_sum = m_sum | pend;
      for (int i = 0; i < 8; i++) begin
        if (reg_wr_en && reg_addr == 12'hC04 + 12'(16*i)) m_sts[i] = m_sts[i] & ~reg_wdata;
        m_sts[i] = m_sts[i] | cap[i];
        if (reg_wr_en && reg_addr == 12'hC00 + 12'(16*i)) m_lo[i]  = reg_wdata;
        if (reg_wr_en && reg_addr == 12'hC08 + 12'(16*i)) m_ven[i] = reg_wdata;
        if (reg_wr_en && reg_addr == 12'hC80 + 12'(4*i))  m_hi[i]  = reg_wdata;
      end
      m_lvl = intx_assert | (m_lvl & ~intx_deassert);
      if (reg_wr_en && reg_addr == 12'h180) begin
        m_ten = reg_wdata[15:8]; m_tix = reg_wdata[27:24];
      end
      if (reg_wr_en && reg_addr == 12'h190) m_sen = reg_wdata[7:0];
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (irq_out !== m_irq()) begin
      bad++;
      $display("FAIL R8 model irq_out act=%0b exp=%0b t=%0t", irq_out, m_irq(), $time);
    end
    total++;
    if (reg_rdata !== mread(reg_addr)) begin
      bad++;
      $display("FAIL R2/R3/R5 model read @%h act=%h exp=%h", reg_addr, reg_rdata, mread(reg_addr));
    end
  end

  task automatic chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk);
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s read @%h act=%h exp=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk);
    total++;
    if (irq_out !== exp) begin
      bad++;
      $display("FAIL %s irq_out act=%0b exp=%0b", req, irq_out, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr_en = 0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(posedge clk); #1 msi_valid = 1; msi_addr = a; msi_data = d;
    @(posedge clk); #1 msi_valid = 0;
  endtask

  task automatic msi_and_clear(input logic [63:0] a, input logic [31:0] d,
                               input logic [11:0] ra, input logic [31:0] rd);
    @(posedge clk); #1 msi_valid = 1; msi_addr = a; msi_data = d;
    reg_wr_en = 1; reg_addr = ra; reg_wdata = rd;
    @(posedge clk); #1 msi_valid = 0; reg_wr_en = 0;
  endtask

  task automatic intx(input logic [3:0] as, input logic [3:0] de);
    @(posedge clk); #1 intx_assert = as; intx_deassert = de;
    @(posedge clk); #1 intx_assert = 0; intx_deassert = 0;
  endtask

  localparam logic [63:0] A2 = 64'h0000_0001_1000_0C20;
  localparam logic [63:0] A7 = 64'h0000_00AB_2000_0000;

  initial begin
    #1000000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", 12'h180, 0); chk("R1", 12'h184, 0); chk("R1", 12'h190, 0);
    chk("R1", 12'hC04, 0); chk("R1", 12'hC9C, 0); chk_irq("R1", 0);
    // R8 enable register field mask
    wr(12'h180, 32'hFFFF_FFFF); chk("R8", 12'h180, 32'h0F00_FF00);
    chk_irq("R8", 0);
    // R2 address programming for set 2 and set 7 boundaries
    wr(12'hC20, A2[31:0]); wr(12'hC88, A2[63:32]);
    wr(12'hC70, A7[31:0]); wr(12'hC9C, A7[63:32]);
    chk("R2", 12'hC20, 32'h1000_0C20); chk("R2", 12'hC88, 32'h1);
    chk("R2", 12'hC9C, 32'hAB);
    wr(12'hC28, 32'hFFFF_FFFF); wr(12'hC78, 32'hFFFF_FFFF);
    // R4 set not yet enabled: dropped
    msi(A2, 5); chk("R4", 12'hC24, 0); chk("R4", 12'h184, 0);
    wr(12'h190, 32'h84);
    // R2 capture vector 5 in set 2
    msi(A2, 5); chk("R2", 12'hC24, 32'h20);
    chk("R5", 12'h184, 32'h0000_0400); chk_irq("R8", 1);
    // R4 out-of-range data and wrong address
    msi(A2, 32); msi(A2 ^ 64'h1_0000_0000, 6);
    chk("R4", 12'hC24, 32'h20);
    // R2 boundary vector 31 in set 7
    msi(A7, 31); chk("R2", 12'hC74, 32'h8000_0000);
    chk("R5", 12'h184, 32'h0000_8400);
    // R3 write 0 no effect, write 1 clears
    wr(12'hC24, 0); chk("R3", 12'hC24, 32'h20);
    wr(12'hC24, 32'h20); wr(12'hC74, 32'h8000_0000);
    chk("R3", 12'hC24, 0);
    chk("R5", 12'h184, 32'h0000_8400);  // sticky after vector clear
    wr(12'h184, 32'h0000_8400); chk("R5", 12'h184, 0); chk_irq("R8", 0);
    // R3 capture wins over same-cycle clear
    msi_and_clear(A2, 7, 12'hC24, 32'h80); chk("R3", 12'hC24, 32'h80);
    // R5 clear while still pending re-arms
    wr(12'h184, 32'h0000_0400); chk("R5", 12'h184, 32'h0000_0400);
    wr(12'hC24, 32'h80); wr(12'h184, 32'h400); chk("R5", 12'h184, 0);
    // R6 vector enable gates only the summary
    wr(12'hC28, 32'hFFFF_FFF7); msi(A2, 3);
    chk("R6", 12'hC24, 32'h08); chk("R6", 12'h184, 0); chk_irq("R6", 0);
    wr(12'hC28, 32'h8); chk("R6", 12'h184, 32'h0000_0400);
    wr(12'hC24, 32'h8); wr(12'h184, 32'h400); chk("R6", 12'h184, 0);
    // R7 INTx level behaviour on line B
    intx(4'b0010, 0); chk("R7", 12'h184, 32'h0200_0000); chk_irq("R7", 1);
    wr(12'h184, 32'h0200_0000); chk("R7", 12'h184, 32'h0200_0000);
    intx(0, 4'b0010); chk("R7", 12'h184, 0); chk_irq("R7", 0);
    // R8 masked INTx does not raise irq
    wr(12'h180, 32'h0000_FF00); intx(4'b1000, 0);
    chk("R8", 12'h184, 32'h0800_0000); chk_irq("R8", 0);
    intx(0, 4'b1000);
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule